// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Transmitter

This block is the sending end of a two-channel serial audio link, and it is the clock master. A system clock is divided by an integer to make a bit clock. From that bit clock the block derives a word-select clock with a 50% duty cycle, and it shifts out one left sample and one right sample per frame on a single serial data line. A frame has two channel slots. Word select is low during the left slot and high during the right slot.

A single datapath builds all three framing formats: standard (the MSB is delayed by one bit period), left-justified, and right-justified. The sample width can be set from 8 to 24 bits. The slot length can be set to 16, 24 or 32 bit periods. Stereo pairs come in through a valid/ready interface, and one pair is taken at the start of each frame. When no pair is waiting, the last pair is sent again and a sticky flag is set. Format, slot and width are captured only when a left slot begins.

Top module: `serial_audio_tx`

## Requirements
- R1: While reset is held, and immediately after it is released, `bclk`, `ws`, `sd`, `underrun` and `inReady` are all 0.
- R2: `bclk` has a period of 2×DIV_HALF system clocks. It is high for DIV_HALF of them and low for DIV_HALF of them.
- R3: A frame lasts 2×S bit periods, where S is the slot length. The slot length is selected by `slotSel`: 0 gives 16, 1 gives 24, and 2 or 3 gives 32. `ws` is 0 for the first S bit periods of a frame (left) and 1 for the last S bit periods (right).
- R4: In standard format (`fmtSel` is 0 or 3), bit period k of a slot carries sample bit W−k for k = 1..W, where W is the effective width. Bit periods after that carry 0. Bit period 0 of a slot carries the LSB of the previous channel's sample when W = S, and 0 otherwise.
- R5: In left-justified format (`fmtSel` = 1), the MSB is in bit period 0 of the slot, which is the period in which `ws` changes. The W sample bits follow MSB first, and the rest of the slot is 0.
- R6: In right-justified format (`fmtSel` = 2), the first S−W bit periods of the slot are 0. The sample follows MSB first, and its LSB is in bit period S−1, the last period before `ws` changes.
- R7: `sd` and `ws` change only after a falling edge of `bclk`. They are constant for the whole time `bclk` is high.
- R8: `inReady` is a pulse one system clock long, once per frame, at the frame boundary. If `inValid` is high in that cycle, `inLeft` and `inRight` are the pair sent in the frame that begins.
- R9: If `inValid` is low when `inReady` pulses, the frame sends the previous pair again and `underrun` becomes 1. `underrun` stays 1 until reset, even after valid pairs are supplied again.
- R10: Values of `fmtSel`, `slotSel` and `widthSel` are captured only at the frame boundary. A change in the middle of a frame does not alter that frame.
- R11: The effective width is `widthSel` limited to the range from 8 to min(S, DATA_W). Sample bits above the effective width are not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtSel | input | 2 | Framing format: 0/3 standard, 1 left-justified, 2 right-justified |
| slotSel | input | 2 | Slot length: 0 = 16, 1 = 24, 2/3 = 32 bit periods |
| widthSel | input | 5 | Requested sample width in bits |
| inValid | input | 1 | A stereo pair is offered |
| inReady | output | 1 | The pair is taken in this cycle (frame boundary) |
| inLeft | input | DATA_W | Left sample, right-aligned in the bus |
| inRight | input | DATA_W | Right sample, right-aligned in the bus |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select: 0 left, 1 right |
| sd | output | 1 | Serial data, updated after each bclk fall |
| underrun | output | 1 | Sticky: a frame had to repeat its pair |

## Verification
The bench builds the block with DIV_HALF = 2 and DATA_W = 24. The short divider keeps even a 64-bit frame down to a few hundred system clocks. At this setting, `sd` updates one system clock after the fall of `bclk`, which is still a full system clock before the next rise. With the full 24-bit bus, every slot length can be paired with both the largest and smallest widths. That makes reachable the case where width equals slot and the LSB carries into the next slot, and the case where a request above the slot length is limited.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    FMT_STD = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_ALT = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [5:0] slotBits;
    logic [5:0] width;
  } cfg_t;

  typedef struct packed {
    logic frameStart;
    logic update;
  } strobe_t;

endpackage

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int DATA_W   = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] fmtIn,
  input  logic [1:0] slotIn,
  input  logic [4:0] widthIn,
  output logic       bclk,
  output logic [5:0] pos,
  output cfg_t       cfg,
  output strobe_t    stb
);

  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CNT_W-1:0] divCnt;
  logic             tick;
  logic             fallNow;
  logic             wrap;
  logic             updQ;
  logic [6:0]       lastPos;
  logic [5:0]       slotDec;
  logic [5:0]       maxW;
  logic [5:0]       wReq;
  logic [5:0]       wClamp;
  cfg_t             nextCfg;

  assign tick    = (divCnt == CNT_W'(DIV_HALF - 1));
  assign fallNow = tick && bclk;
  assign lastPos = {cfg.slotBits, 1'b0} - 7'd1;
  assign wrap    = ({1'b0, pos} >= lastPos);

  always_comb begin
    case (slotIn)
      2'd0:    slotDec = 6'd16;
      2'd1:    slotDec = 6'd24;
      default: slotDec = 6'd32;
    endcase
    maxW = (slotDec < 6'(DATA_W)) ? slotDec : 6'(DATA_W);
    wReq = {1'b0, widthIn};
    if (wReq < 6'd8)       wClamp = 6'd8;
    else if (wReq > maxW)  wClamp = maxW;
    else                   wClamp = wReq;
    nextCfg.fmt      = fmt_e'(fmtIn);
    nextCfg.slotBits = slotDec;
    nextCfg.width    = wClamp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      bclk   <= 1'b0;
      pos    <= 6'h3F;
      cfg    <= '{fmt: FMT_STD, slotBits: 6'd16, width: 6'd16};
      updQ   <= 1'b0;
    end else begin
      divCnt <= tick ? '0 : divCnt + CNT_W'(1);
      if (tick) bclk <= ~bclk;
      if (fallNow) pos <= wrap ? 6'd0 : pos + 6'd1;
      if (fallNow && wrap) cfg <= nextCfg;
      updQ <= fallNow;
    end
  end

  assign stb = '{frameStart: fallNow && wrap, update: updQ};

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameStart |=> !stb.frameStart); // R8

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.frameStart) |-> (cfg == $past(cfg))); // R10

endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [5:0]        pos,
  input  cfg_t              cfg,
  input  logic              bclk,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  output logic              ws,
  output logic              sd,
  output logic              underrun
);

  logic [DATA_W-1:0] leftQ;
  logic [DATA_W-1:0] rightQ;
  logic [DATA_W-1:0] prevRightQ;
  logic [DATA_W-1:0] chanS;
  logic [DATA_W-1:0] prevS;
  logic              isRight;
  logic [5:0]        k;
  logic              nextSd;

  function automatic logic pickBit(input logic [DATA_W-1:0] s, input logic [5:0] j,
                                   input logic [5:0] w, input logic [5:0] slot,
                                   input logic alignEnd);
    logic [5:0] lead;
    logic [5:0] idx;
    lead    = slot - w;
    pickBit = 1'b0;
    if (alignEnd) begin
      if (j >= lead) begin
        idx     = w - 6'd1 - (j - lead);
        pickBit = |(s & ({{(DATA_W-1){1'b0}}, 1'b1} << idx));
      end
    end else if (j < w) begin
      idx     = w - 6'd1 - j;
      pickBit = |(s & ({{(DATA_W-1){1'b0}}, 1'b1} << idx));
    end
  endfunction

  always_comb begin
    isRight = (pos >= cfg.slotBits);
    k       = isRight ? pos - cfg.slotBits : pos;
    chanS   = isRight ? rightQ : leftQ;
    prevS   = isRight ? leftQ : prevRightQ;
    case (cfg.fmt)
      FMT_LJ:  nextSd = pickBit(chanS, k, cfg.width, cfg.slotBits, 1'b0);
      FMT_RJ:  nextSd = pickBit(chanS, k, cfg.width, cfg.slotBits, 1'b1);
      default: nextSd = (k == 6'd0)
                 ? pickBit(prevS, cfg.slotBits - 6'd1, cfg.width, cfg.slotBits, 1'b0)
                 : pickBit(chanS, k - 6'd1, cfg.width, cfg.slotBits, 1'b0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftQ      <= '0;
      rightQ     <= '0;
      prevRightQ <= '0;
      ws         <= 1'b0;
      sd         <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      if (stb.frameStart) begin
        prevRightQ <= rightQ;
        if (inValid) begin
          leftQ  <= inLeft;
          rightQ <= inRight;
        end else begin
          underrun <= 1'b1;
        end
      end
      if (stb.update) begin
        ws <= isRight;
        sd <= nextSd;
      end
    end
  end

  AST_SD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (sd != $past(sd)) |-> !bclk); // R7

  AST_WS_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (ws != $past(ws)) |-> !bclk); // R7

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(underrun) |-> underrun); // R9

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int DATA_W   = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        fmtSel,
  input  logic [1:0]        slotSel,
  input  logic [4:0]        widthSel,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  output logic              bclk,
  output logic              ws,
  output logic              sd,
  output logic              underrun
);

  cfg_t       cfg;
  strobe_t    stb;
  logic [5:0] pos;

  initial begin
    if (DIV_HALF < 2) $error("DIV_HALF must be at least 2");
  end

  sat_ctrl #(.DIV_HALF(DIV_HALF), .DATA_W(DATA_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .fmtIn   (fmtSel),
    .slotIn  (slotSel),
    .widthIn (widthSel),
    .bclk    (bclk),
    .pos     (pos),
    .cfg     (cfg),
    .stb     (stb)
  );

  sat_datapath #(.DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pos      (pos),
    .cfg      (cfg),
    .bclk     (bclk),
    .inValid  (inValid),
    .inLeft   (inLeft),
    .inRight  (inRight),
    .ws       (ws),
    .sd       (sd),
    .underrun (underrun)
  );

  assign inReady = stb.frameStart;

endmodule

// File: tb/tb_serial_audio_tx.sv
module tb_serial_audio_tx;

  localparam int DIV_HALF = 2;
  localparam int DATA_W   = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        fmtSel = 2'd0;
  logic [1:0]        slotSel = 2'd0;
  logic [4:0]        widthSel = 5'd16;
  logic              inValid = 1'b1;
  logic              inReady;
  logic [DATA_W-1:0] inLeft = '0;
  logic [DATA_W-1:0] inRight = '0;
  logic              bclk, ws, sd, underrun;

  int nChecks = 0;
  int nFail   = 0;
  int lastL   = 0;
  int lastR   = 0;

  serial_audio_tx #(.DIV_HALF(DIV_HALF), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .slotSel(slotSel), .widthSel(widthSel),
    .inValid(inValid), .inReady(inReady), .inLeft(inLeft), .inRight(inRight),
    .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  function automatic int slotOf(input int sSel);
    return (sSel == 0) ? 16 : (sSel == 1) ? 24 : 32;
  endfunction

  function automatic int effW(input int wReq, input int slot);
    int m = (slot < DATA_W) ? slot : DATA_W;
    if (wReq < 8) return 8;
    if (wReq > m) return m;
    return wReq;
  endfunction

  function automatic int sBit(input int s, input int j, input int w, input int slot, input bit toEnd);
    int lead = slot - w;
    if (toEnd) return (j >= lead) ? ((s >> (w - 1 - (j - lead))) & 1) : 0;
    return (j >= 0 && j < w) ? ((s >> (w - 1 - j)) & 1) : 0;
  endfunction

  function automatic int expBit(input int fmt, input int slot, input int w, input int L,
                                input int R, input int pR, input int i);
    int c = i / slot;
    int k = i % slot;
    int cur = c ? R : L;
    int prv = c ? L : pR;
    if (fmt == 1) return sBit(cur, k, w, slot, 1'b0);
    if (fmt == 2) return sBit(cur, k, w, slot, 1'b1);
    return (k == 0) ? sBit(prv, slot - 1, w, slot, 1'b0) : sBit(cur, k - 1, w, slot, 1'b0);
  endfunction

  // Capture one frame starting at its first bit period, compare ws and sd.
  task automatic captureCheck(input int fmt, input int slot, input int w, input int L,
                              input int R, input int pR, input bit midChange, input string tag);
    int capSd[65];
    int capWs[65];
    int wsErr = 0;
    int dErr = 0;
    for (int i = 0; i <= 2 * slot; i++) begin
      @(posedge bclk); #1;
      capSd[i] = int'(sd);
      capWs[i] = int'(ws);
      if (midChange && i == 3) begin
        fmtSel = 2'd2;
        widthSel = 5'd8;
      end
    end
    for (int i = 0; i < 2 * slot; i++) begin
      if (capWs[i] != ((i >= slot) ? 1 : 0)) wsErr++;
      if (capSd[i] != expBit(fmt, slot, w, L, R, pR, i)) dErr++;
    end
    chk({"R3 ws halves, ", tag}, wsErr, 0);
    chk({tag, " bit mismatches"}, dErr, 0);
    if (fmt == 0 && w == slot && !midChange)
      chk({"R4 LSB carried into next slot, ", tag}, capSd[2 * slot], R & 1);
  endtask

  task automatic runFrame(input int fmt, input int sSel, input int wReq, input int L,
                          input int R, input bit midChange, input string tag);
    int slot = slotOf(sSel);
    int w = effW(wReq, slot);
    int pR = lastR;
    fmtSel = 2'(fmt);
    slotSel = 2'(sSel);
    widthSel = 5'(wReq);
    inLeft = DATA_W'(L);
    inRight = DATA_W'(R);
    inValid = 1'b1;
    do @(negedge clk); while (!inReady);
    @(negedge clk);
    chk("R8 ready is a single-cycle pulse", int'(inReady), 0);
    captureCheck(fmt, slot, w, L, R, pR, midChange, tag);
    lastL = L;
    lastR = R;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 bclk in reset", int'(bclk), 0);
    chk("R1 ws in reset", int'(ws), 0);
    chk("R1 sd in reset", int'(sd), 0);
    chk("R1 underrun in reset", int'(underrun), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 inReady after reset", int'(inReady), 0);
    chk("R1 bclk after reset", int'(bclk), 0);
  endtask

  task automatic testClock();
    time t0, t1, t2;
    @(posedge bclk); t0 = $time;
    @(negedge bclk); t1 = $time;
    @(posedge bclk); t2 = $time;
    chk("R2 bclk period ns", int'(t2 - t0), 2 * DIV_HALF * 10);
    chk("R2 bclk high time ns", int'(t1 - t0), DIV_HALF * 10);
  endtask

  task automatic testStableHigh();
    int bad = 0;
    int a, b;
    for (int i = 0; i < 32; i++) begin
      @(posedge bclk); #1;
      a = int'(sd);
      b = int'(ws);
      @(negedge bclk); #1;
      if (a != int'(sd) || b != int'(ws)) bad++;
    end
    chk("R7 sd/ws constant while bclk high", bad, 0);
  endtask

  task automatic testUnderrun();
    chk("R9 no underrun while pairs supplied", int'(underrun), 0);
    inValid = 1'b0;
    inLeft = 24'h0F0F0F;
    inRight = 24'hF0F0F0;
    do @(negedge clk); while (!inReady);
    @(negedge clk);
    chk("R9 underrun set on missing pair", int'(underrun), 1);
    // Config inputs left at fmt 2, slot 32, width 8 by the preceding test.
    captureCheck(2, 32, 8, lastL, lastR, lastR, 1'b0, "R9 repeated pair");
    runFrame(1, 0, 16, 16'h1357, 16'h2468, 1'b0, "R5 after underrun");
    chk("R9 underrun stays set", int'(underrun), 1);
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testClock();
    runFrame(0, 0, 16, 24'h00A5C3, 24'h005A3C, 1'b0, "R4 standard w16 s16");
    testStableHigh();
    runFrame(0, 2, 16, 24'h008001, 24'h007FFE, 1'b0, "R4 standard w16 s32");
    runFrame(1, 1, 20, 24'h0F0F0F, 24'h012345, 1'b0, "R5 left-justified w20 s24");
    runFrame(2, 2, 24, 24'hABCDEF, 24'h123456, 1'b0, "R6 right-justified w24 s32");
    runFrame(2, 1, 8, 24'h000096, 24'h000069, 1'b0, "R6 right-justified w8 s24");
    runFrame(1, 0, 24, 24'h3C5A96, 24'hC3A569, 1'b0, "R11 width 24 limited to slot 16");
    runFrame(1, 2, 3, 24'h0000C3, 24'h00003C, 1'b0, "R11 width 3 raised to 8");
    runFrame(0, 2, 16, 24'h001234, 24'h00FEDC, 1'b1, "R10 mid-frame change ignored");
    testUnderrun();
    finishRun();
  end

endmodule